// File: doc/BRIEF.md
# Three-Region Data Memory Decoder

This block places three kinds of storage behind one single-port word interface. Working RAM fills the lower half of the address space. A frame-buffer RAM fills the next quarter. One read-only word at the base of the top quarter returns the code that an external keyboard presents. All remaining addresses in the top quarter are treated as invalid. The two upper address bits pick the region. The remaining lower bits index a word inside the RAM or frame buffer.

A write is accepted on the rising clock edge, and its write-enable reaches only the selected storage array. A read is combinational. The output multiplexer is driven by the same region decode, so the read data follows the address within the same cycle. A synchronous active-high reset blocks all writes while it is high. The memories themselves are not cleared.

The address width `ADDR_W` is a parameter. At `ADDR_W = 15` the map is: RAM at 0x0000–0x3FFF, frame buffer at 0x4000–0x5FFF, keyboard at 0x6000, and invalid addresses at 0x6001–0x7FFF. The default is smaller so that the block elaborates quickly. The requirements below give addresses for `ADDR_W = 15`.

Top module: `mmap_dmem`

## Requirements
- R1: A write with `we`=1 to address 0x0000–0x3FFF stores `din` in working RAM at index `addr[13:0]`. A later read of that address returns the stored word.
- R2: A write to address 0x4000–0x5FFF stores `din` in frame-buffer RAM at index `addr[12:0]`. Frame-buffer storage is separate from working RAM, so a write to 0x4000+k leaves RAM word k unchanged, and the reverse also holds.
- R3: A write takes effect at the rising clock edge. In the cycle of the write, the read data still shows the old word. From the next cycle on, it shows the new word.
- R4: Address 0x6000 returns the `key` input combinationally. A write to 0x6000 is ignored: it changes no RAM or frame-buffer word.
- R5: Addresses 0x6001–0x7FFF read as zero. A write to any of them changes no RAM or frame-buffer word, including the words whose index equals the address's lower bits.
- R6: At most one storage array receives a write-enable in any cycle, and only when `we`=1 and the address lies in that array's region.
- R7: While `rst`=1, no write reaches any storage array. Reads still work, so the keyboard word and invalid addresses behave as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| we | input | 1 | Write request |
| key | input | DATA_W | Code from the keyboard peripheral |
| dout | output | DATA_W | Combinational read data |

## Verification
The map is exercised at both ends of each region (0x0000, 0x3FFF, 0x4000, 0x5FFF) and at interior words. These checks show whether the decode boundaries sit on the correct bit. Aliasing patterns write the same lower index into RAM, the frame buffer, the keyboard word and invalid addresses. They tell correct write steering apart from a decoder that leaks a write into a second region. Back-to-back writes to one word separate the old-data-in-the-write-cycle behaviour from a read that wrongly bypasses the new data. A write attempted during a reset pulse over known contents shows whether the reset gate works.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    // Region picked by the upper address bits
    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_FB   = 2'd1,
        RGN_KEY  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    // Write-enable bundle for the two storage arrays
    typedef struct packed {
        logic ram;
        logic fb;
    } wsel_t;

    function automatic wsel_t steer_write(region_e rgn, logic wr);
        wsel_t s;
        s.ram = wr && (rgn == RGN_RAM);
        s.fb  = wr && (rgn == RGN_FB);
        return s;
    endfunction

endpackage

// File: rtl/mmap_decode.sv
module mmap_decode
    import mmap_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int LOW_W = ADDR_W - 2;

    logic upper;
    logic fb_side_n;
    logic low_zero;

    always_comb begin
        upper     = addr[ADDR_W-1];
        fb_side_n = addr[ADDR_W-2];
        low_zero  = (addr[LOW_W-1:0] == '0);
        if (!upper)
            region = RGN_RAM;
        else if (!fb_side_n)
            region = RGN_FB;
        else if (low_zero)
            region = RGN_KEY;
        else
            region = RGN_NONE;
    end

endmodule

// File: rtl/mmap_bank.sv
module mmap_bank #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr)
            store[idx] <= wdata;
    end

    assign rdata = store[idx];

endmodule

// File: rtl/mmap_dmem.sv
module mmap_dmem
    import mmap_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              we,
    input  logic [DATA_W-1:0] key,
    output logic [DATA_W-1:0] dout
);
    localparam int RAM_IW = ADDR_W - 1;
    localparam int FB_IW  = ADDR_W - 2;

    region_e           region;
    wsel_t             wsel;
    logic              ram_we;
    logic              fb_we;
    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] fb_q;

    mmap_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .region (region)
    );

    always_comb begin
        wsel   = steer_write(region, we && !rst);
        ram_we = wsel.ram;
        fb_we  = wsel.fb;
    end

    mmap_bank #(.DATA_W(DATA_W), .IDX_W(RAM_IW)) u_ram (
        .clk   (clk),
        .wr    (ram_we),
        .idx   (addr[RAM_IW-1:0]),
        .wdata (din),
        .rdata (ram_q)
    );

    mmap_bank #(.DATA_W(DATA_W), .IDX_W(FB_IW)) u_fb (
        .clk   (clk),
        .wr    (fb_we),
        .idx   (addr[FB_IW-1:0]),
        .wdata (din),
        .rdata (fb_q)
    );

    always_comb begin
        unique case (region)
            RGN_RAM: dout = ram_q;
            RGN_FB:  dout = fb_q;
            RGN_KEY: dout = key;
            default: dout = '0;
        endcase
    end

endmodule

// File: rtl/mmap_dmem_chk.sv
module mmap_dmem_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic              we,
    input logic [DATA_W-1:0] key,
    input logic [DATA_W-1:0] dout,
    input logic              ram_we,
    input logic              fb_we
);
    logic in_ram, in_fb, at_key, bad;

    always_comb begin
        in_ram = (addr < (1 << (ADDR_W-1)));
        in_fb  = !in_ram && (addr < ((1 << (ADDR_W-1)) + (1 << (ADDR_W-2))));
        at_key = (addr == ADDR_W'((1 << (ADDR_W-1)) + (1 << (ADDR_W-2))));
        bad    = !in_ram && !in_fb && !at_key;
    end

    // R6: never both arrays written
    a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_we, fb_we}));

    // R6: enable only for the matching region
    a_r6_ram_region: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (we && in_ram));
    a_r6_fb_region: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (we && in_fb));

    // R4: keyboard word reflects key input
    a_r4_key_read: assert property (@(posedge clk) disable iff (rst)
        at_key |-> (dout == key));

    // R5: invalid reads zero and writes go nowhere
    a_r5_bad_zero: assert property (@(posedge clk) disable iff (rst)
        bad |-> (dout == '0));
    a_r5_bad_nowrite: assert property (@(posedge clk) disable iff (rst)
        (we && (bad || at_key)) |-> !(ram_we || fb_we));

    // R7: reset blocks writes
    always_comb begin
        if (rst)
            a_r7_reset_block: assert (!(ram_we || fb_we));
    end

    // R3: a stored word is visible in the following cycle
    a_r3_visible_next: assert property (@(posedge clk) disable iff (rst)
        ($past(we && (in_ram || in_fb) && !rst) && (addr == $past(addr)))
            |-> (dout == $past(din)));

endmodule

bind mmap_dmem mmap_dmem_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .din    (din),
    .we     (we),
    .key    (key),
    .dout   (dout),
    .ram_we (ram_we),
    .fb_we  (fb_we)
);

// File: tb/mmap_dmem_bench.sv
`timescale 1ns/1ps
module mmap_dmem_bench;
    localparam int DW = 16;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          we = 1'b0;
    logic [DW-1:0] key = '0;
    logic [DW-1:0] dout;

    int checks = 0;
    int fails  = 0;

    // Behavioural model: unknown until first written
    logic [DW-1:0] ram_m [int];
    logic [DW-1:0] fb_m  [int];

    always #2.5 clk = ~clk;

    mmap_dmem #(.DATA_W(DW), .ADDR_W(AW)) u_mmap_dmem (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .we(we), .key(key), .dout(dout)
    );

    function automatic logic [DW-1:0] model_read(int a, logic [DW-1:0] k);
        if (a < 'h4000)
            return ram_m.exists(a) ? ram_m[a] : 'x;
        if (a < 'h6000)
            return fb_m.exists(a - 'h4000) ? fb_m[a - 'h4000] : 'x;
        if (a == 'h6000)
            return k;
        return '0;
    endfunction

    // One cycle: drive, compare before the edge, then update model
    task automatic step(input int a, input logic [DW-1:0] d, input logic w,
                        input logic [DW-1:0] k, input logic r, input string tag);
        logic [DW-1:0] exp;
        @(negedge clk);
        addr = AW'(a); din = d; we = w; key = k; rst = r;
        #1;
        exp = model_read(a, k);
        if (!$isunknown(exp)) begin
            checks++;
            if (dout !== exp) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, dout, exp);
            end
        end
        @(posedge clk);
        if (w && !r) begin
            if (a < 'h4000) ram_m[a] = d;
            else if (a < 'h6000) fb_m[a - 'h4000] = d;
        end
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // Reset state: keyboard and invalid reads work, writes blocked (R7)
        step('h6000, 16'h0000, 1'b0, 16'h00A5, 1'b1, "R7 reset key read");
        step('h6123, 16'h0000, 1'b0, 16'h00A5, 1'b1, "R7 reset invalid zero");
        step('h0010, 16'hDEAD, 1'b1, 16'h0000, 1'b1, "R7 write in reset");
        // R1 working RAM, both ends and middle
        step('h0000, 16'h1111, 1'b1, 16'h0, 1'b0, "R1 write low");
        step('h3FFF, 16'h2222, 1'b1, 16'h0, 1'b0, "R1 write high");
        step('h1234, 16'h3333, 1'b1, 16'h0, 1'b0, "R1 write mid");
        step('h0000, 16'h0, 1'b0, 16'h0, 1'b0, "R1 read low");
        step('h3FFF, 16'h0, 1'b0, 16'h0, 1'b0, "R1 read high");
        step('h1234, 16'h0, 1'b0, 16'h0, 1'b0, "R1 read mid");
        // R2 frame buffer, aliasing with RAM index 0 and 0x1FFF
        step('h4000, 16'hA0A0, 1'b1, 16'h0, 1'b0, "R2 write fb low");
        step('h5FFF, 16'hB0B0, 1'b1, 16'h0, 1'b0, "R2 write fb high");
        step('h1FFF, 16'hC0C0, 1'b1, 16'h0, 1'b0, "R2 write ram alias");
        step('h4000, 16'h0, 1'b0, 16'h0, 1'b0, "R2 read fb low");
        step('h5FFF, 16'h0, 1'b0, 16'h0, 1'b0, "R2 read fb high");
        step('h0000, 16'h0, 1'b0, 16'h0, 1'b0, "R2 ram untouched by fb");
        step('h1FFF, 16'h0, 1'b0, 16'h0, 1'b0, "R2 ram alias value");
        // R3 old data during write cycle, new data after
        step('h0042, 16'h0101, 1'b1, 16'h0, 1'b0, "R3 first write");
        step('h0042, 16'h0202, 1'b1, 16'h0, 1'b0, "R3 old data in write cycle");
        step('h0042, 16'h0, 1'b0, 16'h0, 1'b0, "R3 new data next cycle");
        step('h4042, 16'h0303, 1'b1, 16'h0, 1'b0, "R3 fb first write");
        step('h4042, 16'h0404, 1'b1, 16'h0, 1'b0, "R3 fb old data in write cycle");
        step('h4042, 16'h0, 1'b0, 16'h0, 1'b0, "R3 fb new data");
        // R4 keyboard, several codes, write ignored
        step('h6000, 16'h0, 1'b0, 16'h0041, 1'b0, "R4 key A");
        step('h6000, 16'h0, 1'b0, 16'hFFFF, 1'b0, "R4 key all ones");
        step('h6000, 16'h5555, 1'b1, 16'h0083, 1'b0, "R4 key write ignored");
        step('h6000, 16'h0, 1'b0, 16'h0083, 1'b0, "R4 key after write");
        step('h0000, 16'h0, 1'b0, 16'h0, 1'b0, "R4 ram0 unchanged");
        step('h4000, 16'h0, 1'b0, 16'h0, 1'b0, "R4 fb0 unchanged");
        // R5 invalid addresses
        step('h6001, 16'h0, 1'b0, 16'h1234, 1'b0, "R5 read 6001");
        step('h7FFF, 16'h0, 1'b0, 16'h1234, 1'b0, "R5 read 7FFF");
        step('h7FFF, 16'hEEEE, 1'b1, 16'h0, 1'b0, "R5 write 7FFF");
        step('h6042, 16'hEEEE, 1'b1, 16'h0, 1'b0, "R5 write 6042");
        step('h3FFF, 16'h0, 1'b0, 16'h0, 1'b0, "R5 ram alias 3FFF");
        step('h5FFF, 16'h0, 1'b0, 16'h0, 1'b0, "R5 fb alias 1FFF");
        step('h0042, 16'h0, 1'b0, 16'h0, 1'b0, "R5 ram alias 0042");
        step('h4042, 16'h0, 1'b0, 16'h0, 1'b0, "R5 fb alias 0042");
        step('h1FFF, 16'h0, 1'b0, 16'h0, 1'b0, "R5 ram alias 1FFF");
        // R6 many writes across regions, then read all back
        for (int i = 0; i < 8; i++)
            step(i * 'h0C01, 16'(i * 'h1111 + 7), 1'b1, 16'h0, 1'b0, "R6 sweep write");
        for (int i = 0; i < 8; i++)
            step(i * 'h0C01, 16'h0, 1'b0, 16'h0, 1'b0, "R6 sweep read");
        // R7 reset pulse over known contents
        step('h0020, 16'h1234, 1'b1, 16'h0, 1'b0, "R7 set value");
        step('h0020, 16'hFFFF, 1'b1, 16'h0, 1'b1, "R7 write during reset");
        step('h4020, 16'hFFFF, 1'b1, 16'h0, 1'b1, "R7 fb write during reset");
        step('h0020, 16'h0, 1'b0, 16'h0, 1'b0, "R7 value kept");
        step('h4020, 16'h0, 1'b0, 16'h0, 1'b0, "R7 fb unknown skip");
        step('h0042, 16'h0, 1'b0, 16'h0, 1'b0, "R7 other word kept");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule